// File: doc/BRIEF.md
# USB Control Transfer Stage Sequencer

This block follows a control transfer on the default control endpoint of a USB peripheral. Its inputs are events that an upstream packet decoder has already turned into tokens, data bytes, end-of-packet markers with a good/bad flag, and the host's handshake. From these it stores the 8-byte request and works out whether the transfer is a control read, a control write or a no-data control. It then moves through the data and status stages and gives back one handshake code for each host transaction that needs one.

Firmware controls the transfer through a small write port. Every accepted request sets a request-pending flag. While that flag is set, firmware cannot let the endpoint answer from its buffer and cannot close the transfer. Firmware clears the flag, chooses how the endpoint answers (hold off, serve from buffer, or refuse), and finally marks the transfer complete. After that the sequencer runs the status stage without further help. A fresh request abandons whatever transfer was in progress. Tokens that arrive out of order move the sequencer into an error stage and raise an interrupt.

Top module: `ctl_xfer_seq`

## Requirements
- R1: Encodings: token `tok_pid` is 0 for SETUP, 1 for IN and 2 for OUT. Response `rsp_code` is 0 for ACK, 1 for NAK, 2 for STALL, 3 for a data packet from the buffer and 4 for a zero-length packet. A SETUP followed by exactly 8 data bytes and a good packet end gets an ACK one cycle after the packet end, whatever the stage. A SETUP packet with another byte count or a bad end gets no response and changes no state.
- R2: An accepted request sets `req_valid` to 1, forces `rsp_mode` to 0 (NAK) and clears `ccpl`, and pulses `irq_new_req` for one cycle.
- R3: Request bytes b0..b7, in arrival order, appear as `req_type_code`={b1,b0}, `req_value`={b3,b2}, `req_index`={b5,b4} and `req_length`={b7,b6}. They are updated only by an accepted request.
- R4: While `req_valid` is 1, a write that selects buffer mode and a write that sets `ccpl` are both ignored.
- R5: A request accepted during an unfinished transfer, or in the error stage, drops the old transfer. The stage is then taken from the new request alone.
- R6: Stage codes are 0 idle, 1 read data, 2 write data, 3 read status, 4 write status, 5 no-data status and 6 error. If b0 bit 7 is 1, the new stage is 1. If bit 7 is 0 and the length is nonzero, the new stage is 2. If bit 7 is 0 and the length is zero, the new stage is 5.
- R7: Each of the following enters stage 6 and pulses `irq_seq_err`: an IN or OUT token in idle; an OUT token in read data before `ccpl`; an IN in read data after `ccpl`; an IN in write data before `ccpl`; an OUT in write data after `ccpl`; an OUT in write status or no-data status; an IN in read status; a nonzero-length packet in read status. In stage 6, every IN token and every good OUT packet gets STALL until the next accepted request.
- R8: The status stage is armed only when `rsp_mode` is 1 (BUF) and `ccpl` is 1. A status-stage transaction that arrives before it is armed gets NAK, or STALL if `rsp_mode` is 2.
- R9: In read data with the status stage armed, an OUT token moves to stage 3. The zero-length good packet that follows gets ACK and returns the stage to 0.
- R10: With the status stage armed, an IN in write data (the stage moves to 4) or in stage 4 or 5 gets a zero-length packet. A following `hs_ack` returns the stage to 0.
- R11: In the data stage, an IN in read data gets a data packet when `rsp_mode` is BUF. A good OUT packet in write data gets ACK when `rsp_mode` is BUF. Otherwise both get NAK (mode 0) or STALL (mode 2).
- R12: `irq_stage` pulses for one cycle in the same cycle that `stage` takes a new value.
- R13: Firmware port: address 0 with data bit 0 set clears `req_valid`. Address 1 writes `rsp_mode` (0 NAK, 1 BUF, 2 STALL); the value 3 is ignored. Address 2 with data bit 0 set sets `ccpl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | input | 1 | Token event strobe |
| tok_pid | input | 2 | Token kind (0 SETUP, 1 IN, 2 OUT) |
| byte_valid | input | 1 | Data byte strobe |
| byte_data | input | 8 | Data byte |
| pkt_end | input | 1 | End of data packet strobe |
| pkt_ok | input | 1 | Packet received without error |
| hs_ack | input | 1 | Host ACK after a packet sent by the device |
| cpu_we | input | 1 | Firmware write strobe |
| cpu_addr | input | 2 | Firmware write address |
| cpu_wdata | input | 2 | Firmware write data |
| rsp_valid | output | 1 | A response is to be sent |
| rsp_code | output | 3 | Response code |
| stage | output | 3 | Current stage code |
| req_valid | output | 1 | New request pending for firmware |
| rsp_mode | output | 2 | Endpoint response mode |
| ccpl | output | 1 | Control-complete flag |
| req_type_code | output | 16 | Request type and request code |
| req_value | output | 16 | Request value field |
| req_index | output | 16 | Request index field |
| req_length | output | 16 | Request length field |
| irq_new_req | output | 1 | New-request interrupt pulse |
| irq_stage | output | 1 | Stage-change interrupt pulse |
| irq_seq_err | output | 1 | Sequence-error interrupt pulse |

## Verification
Every result is registered. A response, stage change, interrupt pulse, flag update or request-field update is due at the same rising edge that samples the token, packet end, handshake or firmware write that causes it, so it is visible one cycle after the stimulus. The bench drives inputs on falling edges. A behavioural model updates on the same rising edge as the design, and all outputs are compared with the model on the next falling edge. Directed stage checks are made at that same falling edge, just after each stimulus task returns.

// File: rtl/ctl_pkg.sv
`timescale 1ns/1ps
package ctl_pkg;
  localparam int REQ_BYTES = 8;
  localparam int FIELD_W   = 16;

  typedef enum logic [1:0] {PID_SETUP = 2'd0, PID_IN = 2'd1, PID_OUT = 2'd2} pid_e;
  typedef enum logic [1:0] {CTX_NONE = 2'd0, CTX_SETUP = 2'd1, CTX_OUT = 2'd2} ctx_e;
  typedef enum logic [1:0] {MODE_NAK = 2'd0, MODE_BUF = 2'd1, MODE_STALL = 2'd2} mode_e;
  typedef enum logic [2:0] {
    RSP_ACK = 3'd0, RSP_NAK = 3'd1, RSP_STALL = 3'd2, RSP_DATA = 3'd3, RSP_ZLP = 3'd4
  } rsp_e;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0, ST_RD_DATA = 3'd1, ST_WR_DATA = 3'd2, ST_RD_STAT = 3'd3,
    ST_WR_STAT = 3'd4, ST_ND_STAT = 3'd5, ST_SEQ_ERR = 3'd6
  } stage_e;

  // Stage entered right after a request: direction bit first, then length.
  function automatic stage_e first_stage(input logic dir_in, input logic [FIELD_W-1:0] wlen);
    if (dir_in)           return ST_RD_DATA;
    else if (wlen != '0)  return ST_WR_DATA;
    else                  return ST_ND_STAT;
  endfunction

  // Answer for a transaction that cannot proceed yet.
  function automatic rsp_e hold_rsp(input mode_e m);
    return (m == MODE_STALL) ? RSP_STALL : RSP_NAK;
  endfunction
endpackage

// File: rtl/setup_capture.sv
`timescale 1ns/1ps
module setup_capture import ctl_pkg::*; #(
  parameter int CNT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tok_valid,
  input  logic [1:0]         tok_pid,
  input  logic               byte_valid,
  input  logic [7:0]         byte_data,
  input  logic               pkt_end,
  input  logic               pkt_ok,
  output logic               setup_ok,
  output logic               out_end,
  output logic               out_zero,
  output logic               new_dir_in,
  output logic [FIELD_W-1:0] new_len,
  output logic [FIELD_W-1:0] req_type_code,
  output logic [FIELD_W-1:0] req_value,
  output logic [FIELD_W-1:0] req_index,
  output logic [FIELD_W-1:0] req_length
);
  localparam int IDX_W  = $clog2(REQ_BYTES);
  localparam int FLAT_W = 8 * REQ_BYTES;

  ctx_e              ctx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [7:0]        sh_q [REQ_BYTES];
  logic [FLAT_W-1:0] sh_flat;
  logic [FLAT_W-1:0] req_q;

  for (genvar g = 0; g < REQ_BYTES; g++) begin : g_flat
    assign sh_flat[8*g +: 8] = sh_q[g];
  end

  assign setup_ok   = pkt_end && (ctx_q == CTX_SETUP) && pkt_ok && (cnt_q == CNT_W'(REQ_BYTES));
  assign out_end    = pkt_end && (ctx_q == CTX_OUT) && pkt_ok;
  assign out_zero   = (cnt_q == '0);
  assign new_dir_in = sh_q[0][7];
  assign new_len    = {sh_q[REQ_BYTES-1], sh_q[REQ_BYTES-2]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctx_q <= CTX_NONE;
      cnt_q <= '0;
      req_q <= '0;
      for (int i = 0; i < REQ_BYTES; i++) sh_q[i] <= '0;
    end else begin
      if (tok_valid) begin
        ctx_q <= (tok_pid == PID_SETUP) ? CTX_SETUP :
                 (tok_pid == PID_OUT)   ? CTX_OUT   : CTX_NONE;
        cnt_q <= '0;
      end else if (pkt_end) begin
        ctx_q <= CTX_NONE;
      end else if (byte_valid) begin
        if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
        if (ctx_q == CTX_SETUP && cnt_q < CNT_W'(REQ_BYTES))
          sh_q[cnt_q[IDX_W-1:0]] <= byte_data;
      end
      if (setup_ok) req_q <= sh_flat;
    end
  end

  assign req_type_code = req_q[FIELD_W-1:0];
  assign req_value     = req_q[2*FIELD_W-1:FIELD_W];
  assign req_index     = req_q[3*FIELD_W-1:2*FIELD_W];
  assign req_length    = req_q[4*FIELD_W-1:3*FIELD_W];
endmodule

// File: rtl/cpu_regs.sv
`timescale 1ns/1ps
module cpu_regs import ctl_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       setup_ok,
  input  logic       cpu_we,
  input  logic [1:0] cpu_addr,
  input  logic [1:0] cpu_wdata,
  output logic       req_valid,
  output logic [1:0] rsp_mode,
  output logic       ccpl,
  output logic       buf_refused
);
  // A buffer-mode request that the pending flag turns away.
  assign buf_refused = cpu_we && (cpu_addr == 2'd1) && (cpu_wdata == MODE_BUF) && req_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      rsp_mode  <= MODE_NAK;
      ccpl      <= 1'b0;
    end else if (setup_ok) begin
      req_valid <= 1'b1;
      rsp_mode  <= MODE_NAK;
      ccpl      <= 1'b0;
    end else if (cpu_we) begin
      case (cpu_addr)
        2'd0: if (cpu_wdata[0]) req_valid <= 1'b0;
        2'd1: if (cpu_wdata != 2'd3 && !buf_refused) rsp_mode <= cpu_wdata;
        2'd2: if (cpu_wdata[0] && !req_valid) ccpl <= 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/stage_fsm.sv
`timescale 1ns/1ps
module stage_fsm import ctl_pkg::*; (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               setup_ok,
  input  logic               new_dir_in,
  input  logic [FIELD_W-1:0] new_len,
  input  logic               tok_in,
  input  logic               tok_out,
  input  logic               out_end,
  input  logic               out_zero,
  input  logic               hs_ack,
  input  logic [1:0]         mode,
  input  logic               ccpl,
  output logic [2:0]         stage,
  output logic               rsp_valid,
  output logic [2:0]         rsp_code,
  output logic               irq_new_req,
  output logic               irq_stage,
  output logic               irq_seq_err,
  output logic               status_armed
);
  stage_e stage_q, stage_d;
  logic   await_q, await_d;
  logic   rv;
  rsp_e   rc;
  mode_e  m;

  assign m            = mode_e'(mode);
  assign status_armed = ccpl && (m == MODE_BUF);

  always_comb begin
    stage_d = stage_q;
    await_d = await_q;
    rv      = 1'b0;
    rc      = RSP_NAK;
    if (setup_ok) begin
      stage_d = first_stage(new_dir_in, new_len);
      await_d = 1'b0;
      rv      = 1'b1;
      rc      = RSP_ACK;
    end else if (out_end) begin
      rv = 1'b1;
      case (stage_q)
        ST_RD_STAT: if (out_zero) begin rc = RSP_ACK; stage_d = ST_IDLE; end
                    else          begin rc = RSP_STALL; stage_d = ST_SEQ_ERR; end
        ST_WR_DATA: rc = (m == MODE_BUF) ? RSP_ACK : hold_rsp(m);
        ST_RD_DATA: rc = hold_rsp(m);
        default:    begin rc = RSP_STALL; stage_d = ST_SEQ_ERR; end
      endcase
    end else if (tok_in) begin
      rv      = 1'b1;
      await_d = 1'b0;
      case (stage_q)
        ST_RD_DATA:
          if (ccpl) begin rc = RSP_STALL; stage_d = ST_SEQ_ERR; end
          else rc = (m == MODE_BUF) ? RSP_DATA : hold_rsp(m);
        ST_WR_DATA:
          if (!ccpl) begin rc = RSP_STALL; stage_d = ST_SEQ_ERR; end
          else if (status_armed) begin rc = RSP_ZLP; stage_d = ST_WR_STAT; await_d = 1'b1; end
          else rc = hold_rsp(m);
        ST_WR_STAT, ST_ND_STAT:
          if (status_armed) begin rc = RSP_ZLP; await_d = 1'b1; end
          else rc = hold_rsp(m);
        default: begin rc = RSP_STALL; stage_d = ST_SEQ_ERR; end
      endcase
    end else if (tok_out) begin
      await_d = 1'b0;
      case (stage_q)
        ST_RD_DATA:
          if (!ccpl) stage_d = ST_SEQ_ERR;
          else if (status_armed) stage_d = ST_RD_STAT;
        ST_WR_DATA: if (ccpl) stage_d = ST_SEQ_ERR;
        ST_RD_STAT: ;
        default:    stage_d = ST_SEQ_ERR;
      endcase
    end else if (hs_ack && await_q) begin
      await_d = 1'b0;
      if (stage_q == ST_WR_STAT || stage_q == ST_ND_STAT) stage_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q     <= ST_IDLE;
      await_q     <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_code    <= RSP_ACK;
      irq_new_req <= 1'b0;
      irq_stage   <= 1'b0;
      irq_seq_err <= 1'b0;
    end else begin
      stage_q     <= stage_d;
      await_q     <= await_d;
      rsp_valid   <= rv;
      rsp_code    <= rc;
      irq_new_req <= setup_ok;
      irq_stage   <= (stage_d != stage_q);
      irq_seq_err <= (stage_d == ST_SEQ_ERR) && (stage_q != ST_SEQ_ERR);
    end
  end

  assign stage = stage_q;
endmodule

// File: rtl/ctl_xfer_seq.sv
`timescale 1ns/1ps
module ctl_xfer_seq import ctl_pkg::*; #(
  parameter int CNT_W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tok_valid,
  input  logic [1:0]   tok_pid,
  input  logic         byte_valid,
  input  logic [7:0]   byte_data,
  input  logic         pkt_end,
  input  logic         pkt_ok,
  input  logic         hs_ack,
  input  logic         cpu_we,
  input  logic [1:0]   cpu_addr,
  input  logic [1:0]   cpu_wdata,
  output logic         rsp_valid,
  output logic [2:0]   rsp_code,
  output logic [2:0]   stage,
  output logic         req_valid,
  output logic [1:0]   rsp_mode,
  output logic         ccpl,
  output logic [15:0]  req_type_code,
  output logic [15:0]  req_value,
  output logic [15:0]  req_index,
  output logic [15:0]  req_length,
  output logic         irq_new_req,
  output logic         irq_stage,
  output logic         irq_seq_err
);
  logic               setup_ok, out_end, out_zero, new_dir_in;
  logic [FIELD_W-1:0] new_len;
  logic               tok_in, tok_out, buf_refused, status_armed;

  assign tok_in  = tok_valid && (tok_pid == PID_IN);
  assign tok_out = tok_valid && (tok_pid == PID_OUT);

  setup_capture #(.CNT_W(CNT_W)) u_cap (
    .clk, .rst_n, .tok_valid, .tok_pid, .byte_valid, .byte_data, .pkt_end, .pkt_ok,
    .setup_ok, .out_end, .out_zero, .new_dir_in, .new_len,
    .req_type_code, .req_value, .req_index, .req_length
  );

  cpu_regs u_regs (
    .clk, .rst_n, .setup_ok, .cpu_we, .cpu_addr, .cpu_wdata,
    .req_valid, .rsp_mode, .ccpl, .buf_refused
  );

  stage_fsm u_fsm (
    .clk, .rst_n, .setup_ok, .new_dir_in, .new_len, .tok_in, .tok_out,
    .out_end, .out_zero, .hs_ack, .mode(rsp_mode), .ccpl,
    .stage, .rsp_valid, .rsp_code, .irq_new_req, .irq_stage, .irq_seq_err, .status_armed
  );
endmodule

// File: rtl/ctl_xfer_seq_chk.sv
`timescale 1ns/1ps
module ctl_xfer_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       setup_ok,
  input logic       buf_refused,
  input logic       status_armed,
  input logic       rsp_valid,
  input logic [2:0] rsp_code,
  input logic [2:0] stage,
  input logic       req_valid,
  input logic [1:0] rsp_mode,
  input logic       ccpl,
  input logic       irq_stage,
  input logic       irq_seq_err
);
  assert_setup_ack_R1: assert property (@(posedge clk) disable iff (!rst_n)
    setup_ok |=> (rsp_valid && rsp_code == 3'd0));

  assert_new_req_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
    setup_ok |=> (req_valid && rsp_mode == 2'd0 && !ccpl));

  assert_pending_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (rsp_mode != 2'd1 && !ccpl));

  assert_refused_buf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_refused |=> (rsp_mode != 2'd1));

  assert_err_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == 3'd6 && rsp_valid) |-> (rsp_code == 3'd2));

  assert_err_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_seq_err |-> (stage == 3'd6));

  assert_zlp_armed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == 3'd4) |-> $past(status_armed));

  assert_read_status_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == 3'd0 && $past(stage) == 3'd3) |-> (rsp_valid && rsp_code == 3'd0));

  assert_stage_irq_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (stage != $past(stage)) |-> irq_stage);
endmodule

bind ctl_xfer_seq ctl_xfer_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .setup_ok(setup_ok), .buf_refused(buf_refused),
  .status_armed(status_armed), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
  .stage(stage), .req_valid(req_valid), .rsp_mode(rsp_mode), .ccpl(ccpl),
  .irq_stage(irq_stage), .irq_seq_err(irq_seq_err)
);

// File: tb/sim_ctl_xfer_seq.sv
`timescale 1ns/1ps
module sim_ctl_xfer_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tok_valid = 0, byte_valid = 0, pkt_end = 0, pkt_ok = 0, hs_ack = 0, cpu_we = 0;
  logic [1:0] tok_pid = 0, cpu_addr = 0, cpu_wdata = 0;
  logic [7:0] byte_data = 0;
  logic rsp_valid, req_valid, ccpl, irq_new_req, irq_stage, irq_seq_err;
  logic [2:0] rsp_code, stage;
  logic [1:0] rsp_mode;
  logic [15:0] req_type_code, req_value, req_index, req_length;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ctl_xfer_seq u0 (.*);

  // Behavioural model state
  int m_stage, m_mode, m_ctx, m_rc;
  bit m_await, m_valid, m_ccpl, m_rv, m_irq_new, m_irq_stage, m_irq_err;
  byte unsigned m_q[$];
  byte unsigned m_req[8];

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int stall_or_nak(int md);
    return (md == 2) ? 2 : 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stage = 0; m_mode = 0; m_ctx = 0; m_rc = 0; m_await = 0; m_valid = 0; m_ccpl = 0;
      m_rv = 0; m_irq_new = 0; m_irq_stage = 0; m_irq_err = 0; m_q.delete();
      foreach (m_req[i]) m_req[i] = 0;
    end else begin
      int nxt; bit ready, sok, oend; int len;
      nxt = m_stage; ready = m_ccpl && (m_mode == 1);
      sok  = pkt_end && m_ctx == 1 && pkt_ok && m_q.size() == 8;
      oend = pkt_end && m_ctx == 2 && pkt_ok;
      m_rv = 0;
      if (sok) begin
        len = m_q[6] + 256 * m_q[7];
        nxt = m_q[0][7] ? 1 : (len != 0 ? 2 : 5);
        m_await = 0; m_rv = 1; m_rc = 0;
      end else if (oend) begin
        m_rv = 1;
        if (m_stage == 3) begin
          if (m_q.size() == 0) begin m_rc = 0; nxt = 0; end else begin m_rc = 2; nxt = 6; end
        end else if (m_stage == 2) m_rc = (m_mode == 1) ? 0 : stall_or_nak(m_mode);
        else if (m_stage == 1) m_rc = stall_or_nak(m_mode);
        else begin m_rc = 2; nxt = 6; end
      end else if (tok_valid && tok_pid == 1) begin
        m_rv = 1; m_await = 0;
        if (m_stage == 1) begin
          if (m_ccpl) begin m_rc = 2; nxt = 6; end else m_rc = (m_mode == 1) ? 3 : stall_or_nak(m_mode);
        end else if (m_stage == 2) begin
          if (!m_ccpl) begin m_rc = 2; nxt = 6; end
          else if (ready) begin m_rc = 4; nxt = 4; m_await = 1; end
          else m_rc = stall_or_nak(m_mode);
        end else if (m_stage == 4 || m_stage == 5) begin
          if (ready) begin m_rc = 4; m_await = 1; end else m_rc = stall_or_nak(m_mode);
        end else begin m_rc = 2; nxt = 6; end
      end else if (tok_valid && tok_pid == 2) begin
        m_await = 0;
        if (m_stage == 1) begin
          if (!m_ccpl) nxt = 6; else if (ready) nxt = 3;
        end else if (m_stage == 2) begin
          if (m_ccpl) nxt = 6;
        end else if (m_stage != 3) nxt = 6;
      end else if (hs_ack && m_await) begin
        m_await = 0;
        if (m_stage == 4 || m_stage == 5) nxt = 0;
      end
      m_irq_new = sok; m_irq_stage = (nxt != m_stage); m_irq_err = (nxt == 6 && m_stage != 6);
      m_stage = nxt;
      if (sok) begin m_valid = 1; m_mode = 0; m_ccpl = 0; end
      else if (cpu_we) begin
        if (cpu_addr == 0 && cpu_wdata[0]) m_valid = 0;
        if (cpu_addr == 1 && cpu_wdata != 3 && !(cpu_wdata == 1 && m_valid)) m_mode = cpu_wdata;
        if (cpu_addr == 2 && cpu_wdata[0] && !m_valid) m_ccpl = 1;
      end
      if (sok) foreach (m_req[i]) m_req[i] = m_q[i];
      if (tok_valid) begin
        m_ctx = (tok_pid == 0) ? 1 : (tok_pid == 2) ? 2 : 0; m_q.delete();
      end else if (pkt_end) m_ctx = 0;
      else if (byte_valid && m_q.size() < 15) m_q.push_back(byte_data);
    end
  end

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1 rsp_valid", rsp_valid, m_rv);
      if (m_rv) chk("R11 rsp_code", rsp_code, m_rc);
      chk("R12 stage", stage, m_stage);
      chk("R12 irq_stage", irq_stage, m_irq_stage);
      chk("R7 irq_seq_err", irq_seq_err, m_irq_err);
      chk("R2 irq_new_req", irq_new_req, m_irq_new);
      chk("R4 req_valid", req_valid, m_valid);
      chk("R13 rsp_mode", rsp_mode, m_mode);
      chk("R8 ccpl", ccpl, m_ccpl);
      chk("R3 type_code", req_type_code, m_req[0] + 256 * m_req[1]);
      chk("R3 value", req_value, m_req[2] + 256 * m_req[3]);
      chk("R3 index", req_index, m_req[4] + 256 * m_req[5]);
      chk("R3 length", req_length, m_req[6] + 256 * m_req[7]);
    end
  end

  task automatic tok(int pid);
    tok_valid = 1; tok_pid = 2'(pid); @(negedge clk); tok_valid = 0;
  endtask
  task automatic bytes(byte unsigned b[$]);
    foreach (b[i]) begin byte_valid = 1; byte_data = b[i]; @(negedge clk); end
    byte_valid = 0;
  endtask
  task automatic pend(bit ok);
    pkt_end = 1; pkt_ok = ok; @(negedge clk); pkt_end = 0;
  endtask
  task automatic cpu(int a, int d);
    cpu_we = 1; cpu_addr = 2'(a); cpu_wdata = 2'(d); @(negedge clk); cpu_we = 0;
  endtask
  task automatic ack();
    hs_ack = 1; @(negedge clk); hs_ack = 0;
  endtask
  task automatic setup(byte unsigned b[$]);
    tok(0); bytes(b); pend(1);
  endtask
  task automatic out_pkt(byte unsigned b[$]);
    tok(2); bytes(b); pend(1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R12 reset stage", stage, 0);
    chk("R4 reset valid", req_valid, 0);

    // Control read
    setup('{8'h80, 8'h06, 8'h00, 8'h01, 8'h00, 8'h00, 8'h12, 8'h00});
    chk("R1 setup ack", rsp_code, 0);
    chk("R6 read stage", stage, 1);
    chk("R3 length field", req_length, 16'h0012);
    cpu(1, 1); chk("R4 buf refused", rsp_mode, 0);
    cpu(2, 1); chk("R4 ccpl refused", ccpl, 0);
    tok(1); chk("R11 nak while held", rsp_code, 1);
    cpu(0, 1); cpu(1, 1);
    tok(1); chk("R11 data from buffer", rsp_code, 3);
    cpu(2, 1);
    tok(2); chk("R9 read status stage", stage, 3);
    pend(1); chk("R9 status ack", rsp_code, 0); chk("R9 back to idle", stage, 0);

    // Control write ending in an error
    setup('{8'h00, 8'h09, 8'h01, 8'h00, 8'h00, 8'h00, 8'h04, 8'h00});
    chk("R6 write stage", stage, 2);
    cpu(0, 1); cpu(1, 1);
    out_pkt('{8'h11, 8'h22, 8'h33, 8'h44}); chk("R11 write ack", rsp_code, 0);
    tok(1); chk("R7 early IN error", stage, 6);
    tok(1); chk("R7 stall in error", rsp_code, 2);

    // Leaving the error stage through a new write request
    setup('{8'h21, 8'h09, 8'h00, 8'h02, 8'h00, 8'h00, 8'h02, 8'h00});
    chk("R5 error abandoned", stage, 2);
    out_pkt('{8'h01, 8'h02}); chk("R11 write nak", rsp_code, 1);
    cpu(0, 1); cpu(1, 1);
    out_pkt('{8'h01, 8'h02}); chk("R11 write ack again", rsp_code, 0);
    cpu(2, 1);
    tok(1); chk("R10 zlp sent", rsp_code, 4); chk("R10 write status", stage, 4);
    tok(1); chk("R10 zlp resent", rsp_code, 4);
    ack(); chk("R10 idle after ack", stage, 0);

    // No-data request
    setup('{8'h00, 8'h05, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00});
    chk("R6 no-data stage", stage, 5);
    tok(1); chk("R8 not armed nak", rsp_code, 1);
    cpu(0, 1); cpu(2, 1);
    tok(1); chk("R8 mode still nak", rsp_code, 1);
    cpu(1, 1);
    tok(1); chk("R10 nodata zlp", rsp_code, 4);
    ack(); chk("R10 nodata idle", stage, 0);

    // Abandon a read in progress
    setup('{8'h80, 8'h06, 8'h00, 8'h02, 8'h00, 8'h00, 8'h40, 8'h00});
    cpu(0, 1); cpu(1, 1); tok(1);
    setup('{8'h00, 8'h05, 8'h07, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00});
    chk("R5 new request wins", stage, 5);
    chk("R2 mode forced nak", rsp_mode, 0);

    // Malformed setup packets change nothing
    tok(0); bytes('{8'h80, 8'h06, 8'h00, 8'h01, 8'h00, 8'h00, 8'h12}); pend(1);
    chk("R1 short setup ignored", rsp_valid, 0);
    tok(0); bytes('{8'h80, 8'h06, 8'h00, 8'h01, 8'h00, 8'h00, 8'h12, 8'h00}); pend(0);
    chk("R1 bad setup ignored", stage, 5);
    chk("R3 value kept", req_value, 16'h0007);

    // Read status out of order and with data
    setup('{8'h80, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h02, 8'h00});
    out_pkt('{}); chk("R7 early status error", stage, 6);
    setup('{8'h80, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h02, 8'h00});
    cpu(0, 1); cpu(1, 1); cpu(2, 1);
    out_pkt('{8'h55, 8'h66}); chk("R9 nonzero status stall", rsp_code, 2);

    // Stall mode and the ignored mode value
    setup('{8'h40, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h00});
    cpu(0, 1); cpu(1, 2);
    out_pkt('{8'h09}); chk("R11 stall mode", rsp_code, 2);
    cpu(1, 3); chk("R13 value 3 ignored", rsp_mode, 2);

    // Token while idle
    setup('{8'h00, 8'h05, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00});
    cpu(0, 1); cpu(1, 1); cpu(2, 1); tok(1); ack();
    tok(1); chk("R7 idle IN error", stage, 6);

    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule